// File: doc/BRIEF.md
# Peripheral Reset and Two-Wire Mode Strap Sequencer

This block sits on the host side of a peripheral that reads two mode-strap pins at the rising edge of its active-low reset and uses them to choose its control interface. When the host asks for it, the sequencer pulls the reset low, sets the straps to the levels that select the two-wire interface, and holds the two-wire clock and data lines high. It then releases reset, keeps the straps in place for a short hold window, and stops driving the straps. Throughout this, the clock line stays high and the data line never falls.

Every minimum time is a parameter in nanoseconds. The block converts each one to system clock cycles and rounds up. The strap setup window depends on the strap-drive flag captured with the request. When the straps are left floating, the peripheral's internal weak pulls must have time to set the levels, so the window is long. When the host drives both straps, the window is short. In both cases the window is never shorter than the guard time in which no START may occur before the reset edge.

After the hold window, the sequencer goes to its ready state. It keeps owning the bus until the clock line has been high for the START setup time. At that point it raises the first-START permission for the separate two-wire master. When the master acknowledges, the sequencer releases both lines and the master issues its first START.

Top module: `rstmode_seq`

## Requirements
- R1: After the synchronous reset the outputs are: peripheral reset low, busy low, first-START permission low, both strap enables low, and neither bus line driven.
- R2: A request sampled in the idle state gives, in the next cycle: busy high, peripheral reset low, and both clock and data lines driven high (enable 1, level 1).
- R3: With the strap-drive flag low at the request, the straps stay undriven (enables 2'b00). The peripheral reset stays low for max(ceil(100 µs), ceil(300 ns)) clock cycles, counted from the first busy cycle, and then rises.
- R4: With the strap-drive flag high at the request, both strap enables are 1 from the first busy cycle. The levels are 2'b01 (bit 0, the first strap, high; bit 1, the second strap, low). The reset-low window is max(ceil(30 ns), ceil(300 ns)) cycles.
- R5: The clock and data lines are driven high in every cycle from the first busy cycle until hand-off, including the cycle in which reset rises. The data line therefore never falls during the guard window.
- R6: The straps, when driven, stay enabled for exactly ceil(30 ns)+1 cycles, counted from the first cycle with reset high. Busy falls in the same cycle that the strap enables drop.
- R7: First-START permission rises in the ready state, in the first cycle in which the clock line has been driven high for ceil(600 ns) cycles since the first busy cycle. It stays high until hand-off.
- R8: A master acknowledge sampled while permission is high releases both bus lines in the next cycle and clears permission. The peripheral reset stays high. An acknowledge sampled while permission is low has no effect.
- R9: While busy, a new request and any change of the strap-drive flag are ignored. Timing and strap enables follow the flag captured at the accepted request.
- R10: A request sampled in the ready state, before or after hand-off, restarts the sequence: in the next cycle the reset is low and busy is high.
- R11: The synchronous reset, asserted in any state, returns the block to idle in the next cycle with the peripheral reset low and all drives off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| srst_i | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Request to run the reset and mode-select sequence |
| drive_straps_i | input | 1 | 1: host drives both straps; 0: straps left floating |
| mst_ack_i | input | 1 | Two-wire master has taken the bus |
| periph_rst_n_o | output | 1 | Active-low reset to the peripheral |
| strap_oe_o | output | 2 | Strap output enables (bit 0 first strap, bit 1 second) |
| strap_lvl_o | output | 2 | Strap levels, 2'b01 selects the two-wire interface |
| scl_oe_o | output | 1 | Clock line drive enable |
| scl_o | output | 1 | Clock line level when driven |
| sda_oe_o | output | 1 | Data line drive enable |
| sda_o | output | 1 | Data line level when driven |
| busy_o | output | 1 | Sequence in progress (setup, release or hold) |
| first_start_ok_o | output | 1 | Master may issue its first START |

## Verification
Every output is decoded from registered state, so a request or acknowledge sampled at a clock edge shows on the outputs one cycle later. Counting that first busy cycle as t=1, the reset rises at t = 1 + low window, busy and the strap enables fall at t = low window + hold + 2, and permission rises at t = 1 + max(low + hold + 1, START setup). The bench drives inputs on falling edges and samples on the next falling edge. It records the cycle index at which each event first appears and compares it with these sums, worked out from the nanosecond values and the 100 MHz clock. It also checks the line and strap levels in every cycle of each run.

// File: rtl/rstmode_pkg.sv
package rstmode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RELEASE,
        ST_HOLD,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       drv_mode;
        logic       own;
    } seq_regs_t;

    // ceiling of ns * hz / 1e9
    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                     longint unsigned hz);
        return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstmode_timer.sv
module rstmode_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         srst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/rstmode_sclage.sv
module rstmode_sclage #(
    parameter int unsigned LIMIT = 60,
    localparam int unsigned W    = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic clear_i,
    input  logic run_i,
    output logic sat_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } age_regs_t;

    age_regs_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (clear_i) begin
            age_d.cnt = '0;
        end else if (run_i && !sat_o) begin
            age_d.cnt = age_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    assign sat_o = (age_q.cnt == W'(LIMIT));

endmodule

// File: rtl/rstmode_fsm.sv
module rstmode_fsm
    import rstmode_pkg::*;
#(
    parameter int unsigned CW       = 14,
    parameter int unsigned LOW_WEAK = 10000,
    parameter int unsigned LOW_DRV  = 30,
    parameter int unsigned HOLD     = 3
) (
    input  logic          clk_i,
    input  logic          srst_i,
    input  logic          go_i,
    input  logic          drive_straps_i,
    input  logic          mst_ack_i,
    input  logic          tmr_zero_i,
    input  logic          age_sat_i,
    output seq_state_e    state_o,
    output logic          drv_mode_o,
    output logic          own_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          age_clear_o,
    output logic          ready_o
);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;
        age_clear_o = 1'b0;
        ready_o     = (r_q.state == ST_READY) && r_q.own && age_sat_i;
        unique case (r_q.state)
            ST_IDLE, ST_READY: begin
                if (go_i) begin
                    r_d.state   = ST_SETUP;
                    r_d.drv_mode = drive_straps_i;
                    r_d.own     = 1'b1;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = drive_straps_i ? CW'(LOW_DRV - 1) : CW'(LOW_WEAK - 1);
                    age_clear_o = 1'b1;
                end else if (ready_o && mst_ack_i) begin
                    r_d.own = 1'b0;
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) begin
                    r_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = CW'(HOLD - 1);
                r_d.state  = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_zero_i) begin
                    r_d.state = ST_READY;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            r_q.state    <= ST_IDLE;
            r_q.drv_mode <= 1'b0;
            r_q.own      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.state;
    assign drv_mode_o = r_q.drv_mode;
    assign own_o      = r_q.own;

    // R9
    mode_latched_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (r_q.state inside {ST_SETUP, ST_RELEASE, ST_HOLD}) |=> $stable(r_q.drv_mode));

    // R9
    go_while_busy_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (go_i && r_q.state == ST_SETUP && !tmr_zero_i) |=> (r_q.state == ST_SETUP));

    // R11
    srst_idle_chk: assert property (@(posedge clk_i)
        srst_i |=> (r_q.state == ST_IDLE && !r_q.own));

endmodule

// File: rtl/rstmode_pads.sv
module rstmode_pads
    import rstmode_pkg::*;
(
    input  seq_state_e  state_i,
    input  logic        drv_mode_i,
    input  logic        own_i,
    output logic        rst_n_o,
    output logic        busy_o,
    output logic [1:0]  strap_oe_o,
    output logic [1:0]  strap_lvl_o,
    output logic        scl_oe_o,
    output logic        scl_o,
    output logic        sda_oe_o,
    output logic        sda_o
);

    always_comb begin
        rst_n_o     = (state_i == ST_RELEASE) || (state_i == ST_HOLD) || (state_i == ST_READY);
        busy_o      = (state_i == ST_SETUP) || (state_i == ST_RELEASE) || (state_i == ST_HOLD);
        strap_oe_o  = (busy_o && drv_mode_i) ? 2'b11 : 2'b00;
        strap_lvl_o = 2'b01;
        scl_oe_o    = own_i;
        scl_o       = 1'b1;
        sda_oe_o    = own_i;
        sda_o       = 1'b1;
    end

endmodule

// File: rtl/rstmode_seq.sv
module rstmode_seq
    import rstmode_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 100_000_000,
    parameter int unsigned WEAK_SETUP_NS   = 100_000,
    parameter int unsigned DRIVEN_SETUP_NS = 30,
    parameter int unsigned STRAP_HOLD_NS   = 30,
    parameter int unsigned START_GUARD_NS  = 300,
    parameter int unsigned START_SETUP_NS  = 600
) (
    input  logic       clk_i,
    input  logic       srst_i,
    input  logic       go_i,
    input  logic       drive_straps_i,
    input  logic       mst_ack_i,
    output logic       periph_rst_n_o,
    output logic [1:0] strap_oe_o,
    output logic [1:0] strap_lvl_o,
    output logic       scl_oe_o,
    output logic       scl_o,
    output logic       sda_oe_o,
    output logic       sda_o,
    output logic       busy_o,
    output logic       first_start_ok_o
);

    localparam int unsigned WEAK_CYC  = 32'(ns_to_cycles(64'(WEAK_SETUP_NS), 64'(CLK_HZ)));
    localparam int unsigned DRV_CYC   = 32'(ns_to_cycles(64'(DRIVEN_SETUP_NS), 64'(CLK_HZ)));
    localparam int unsigned HOLD_CYC  = 32'(ns_to_cycles(64'(STRAP_HOLD_NS), 64'(CLK_HZ)));
    localparam int unsigned GUARD_CYC = 32'(ns_to_cycles(64'(START_GUARD_NS), 64'(CLK_HZ)));
    localparam int unsigned SUSTA_CYC = 32'(ns_to_cycles(64'(START_SETUP_NS), 64'(CLK_HZ)));
    localparam int unsigned LOW_WEAK  = max2(WEAK_CYC, GUARD_CYC);
    localparam int unsigned LOW_DRV   = max2(DRV_CYC, GUARD_CYC);
    localparam int unsigned CW        = $clog2(max2(max2(LOW_WEAK, LOW_DRV), HOLD_CYC + 2) + 1);

    seq_state_e    state;
    logic          drv_mode;
    logic          own;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          age_clear;
    logic          age_sat;

    rstmode_fsm #(
        .CW       (CW),
        .LOW_WEAK (LOW_WEAK),
        .LOW_DRV  (LOW_DRV),
        .HOLD     (HOLD_CYC)
    ) u_fsm (
        .clk_i          (clk_i),
        .srst_i         (srst_i),
        .go_i           (go_i),
        .drive_straps_i (drive_straps_i),
        .mst_ack_i      (mst_ack_i),
        .tmr_zero_i     (tmr_zero),
        .age_sat_i      (age_sat),
        .state_o        (state),
        .drv_mode_o     (drv_mode),
        .own_o          (own),
        .tmr_load_o     (tmr_load),
        .tmr_val_o      (tmr_val),
        .age_clear_o    (age_clear),
        .ready_o        (first_start_ok_o)
    );

    rstmode_timer #(.W(CW)) u_timer (
        .clk_i      (clk_i),
        .srst_i     (srst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rstmode_sclage #(.LIMIT(SUSTA_CYC)) u_age (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .clear_i (age_clear),
        .run_i   (own),
        .sat_o   (age_sat)
    );

    rstmode_pads u_pads (
        .state_i     (state),
        .drv_mode_i  (drv_mode),
        .own_i       (own),
        .rst_n_o     (periph_rst_n_o),
        .busy_o      (busy_o),
        .strap_oe_o  (strap_oe_o),
        .strap_lvl_o (strap_lvl_o),
        .scl_oe_o    (scl_oe_o),
        .scl_o       (scl_o),
        .sda_oe_o    (sda_oe_o),
        .sda_o       (sda_o)
    );

    // Window counters observed by the assertions below
    typedef struct packed {
        logic [CW-1:0] low_run;
        logic [CW-1:0] hold_run;
    } win_regs_t;

    win_regs_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (!busy_o) begin
            win_d.low_run = '0;
        end else if (!periph_rst_n_o) begin
            win_d.low_run = win_q.low_run + CW'(1);
        end
        if (!periph_rst_n_o) begin
            win_d.hold_run = '0;
        end else if (strap_oe_o[0]) begin
            win_d.hold_run = win_q.hold_run + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // R3 R4
    low_width_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(periph_rst_n_o) |->
            (win_q.low_run == (drv_mode ? CW'(LOW_DRV) : CW'(LOW_WEAK))));

    // R5
    scl_at_release_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(periph_rst_n_o) |-> (scl_oe_o && scl_o && sda_oe_o && sda_o));

    // R6
    strap_hold_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (periph_rst_n_o && $fell(strap_oe_o[0])) |-> (win_q.hold_run == CW'(HOLD_CYC + 1)));

    // R7
    ready_age_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        first_start_ok_o |-> (age_sat && periph_rst_n_o && scl_oe_o && !busy_o));

    // R8
    handoff_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (first_start_ok_o && mst_ack_i && !go_i) |=>
            (!scl_oe_o && !sda_oe_o && periph_rst_n_o && !first_start_ok_o));

endmodule

// File: tb/sim_rstmode_seq.sv
module sim_rstmode_seq;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       srst, go, drv, ack;
    logic       rst_n, scl_oe, scl, sda_oe, sda, busy, rdy;
    logic [1:0] strap_oe, strap_lvl;

    rstmode_seq u0 (
        .clk_i            (clk),
        .srst_i           (srst),
        .go_i             (go),
        .drive_straps_i   (drv),
        .mst_ack_i        (ack),
        .periph_rst_n_o   (rst_n),
        .strap_oe_o       (strap_oe),
        .strap_lvl_o      (strap_lvl),
        .scl_oe_o         (scl_oe),
        .scl_o            (scl),
        .sda_oe_o         (sda_oe),
        .sda_o            (sda),
        .busy_o           (busy),
        .first_start_ok_o (rdy)
    );

    localparam longint CLK_MHZ = 100;

    function automatic int cyc(longint ns);
        return int'((ns * CLK_MHZ + 999) / 1000);
    endfunction

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int GUARD = cyc(300);
    localparam int LOW_W = mx(cyc(100000), GUARD);
    localparam int LOW_D = mx(cyc(30), GUARD);
    localparam int HOLD  = cyc(30);
    localparam int SUSTA = cyc(600);

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic bit bus_high();
        return scl_oe && scl && sda_oe && sda;
    endfunction

    function automatic bit all_off();
        return !rst_n && !busy && !rdy && strap_oe == 2'b00 && !scl_oe && !sda_oe;
    endfunction

    // One full sequence with disturbances while busy; ends in READY with permission high
    task automatic run_seq(input bit mode, input string tag);
        int low, busy_end, rdy_exp, t_end;
        int rst_rise, busy_fall, rdy_t, strap_bad, lvl_bad, bus_bad;
        bit scl_at_edge;
        logic [1:0] exp_oe;
        low       = mode ? LOW_D : LOW_W;
        busy_end  = low + HOLD + 2;
        rdy_exp   = 1 + mx(low + 1 + HOLD, SUSTA);
        t_end     = rdy_exp + 2;
        rst_rise  = -1; busy_fall = -1; rdy_t = -1;
        strap_bad = 0; lvl_bad = 0; bus_bad = 0; scl_at_edge = 1'b0;
        @(negedge clk); go = 1'b1; drv = mode;
        @(negedge clk); go = 1'b0;
        chk(!rst_n && busy && bus_high(), {tag, " first busy cycle"}, {rst_n, busy, bus_high()}, 3'b011);
        for (int t = 1; t <= t_end; t++) begin
            if (t > 1) @(negedge clk);
            if (rst_n && rst_rise < 0) begin
                rst_rise    = t;
                scl_at_edge = bus_high();
            end
            if (!busy && busy_fall < 0) busy_fall = t;
            if (rdy && rdy_t < 0) rdy_t = t;
            exp_oe = (mode && t < busy_end) ? 2'b11 : 2'b00;
            if (strap_oe !== exp_oe) strap_bad++;
            if (strap_oe != 2'b00 && strap_lvl !== 2'b01) lvl_bad++;
            if (!bus_high()) bus_bad++;
            // R9 disturbances: repeat request and flipped flag while busy
            go = (t == 2);
            if (t == 2) drv = ~mode;
            // R8 acknowledges while permission is low
            ack = (t == low + 2) || (t == busy_end && rdy_exp > busy_end);
        end
        go = 1'b0; ack = 1'b0;
        chk(rst_rise == 1 + low, mode ? "R4 reset-low window" : "R3 reset-low window", rst_rise, 1 + low);
        chk(scl_at_edge, "R5 clock high at reset edge", scl_at_edge, 1);
        chk(bus_bad == 0, "R5 lines held high while owned", bus_bad, 0);
        chk(busy_fall == busy_end, "R6 busy end", busy_fall, busy_end);
        chk(strap_bad == 0, mode ? "R6 strap hold window" : "R3 straps undriven", strap_bad, 0);
        if (mode) chk(lvl_bad == 0, "R4 strap levels", lvl_bad, 0);
        chk(rdy_t == rdy_exp, "R7 first-START permission cycle", rdy_t, rdy_exp);
        chk(rdy && bus_high(), "R7 permission held", rdy, 1);
        chk(rst_rise == 1 + low && strap_bad == 0, "R9 disturbances ignored", rst_rise, 1 + low);
        chk(rdy_t == rdy_exp, "R8 early acknowledge ignored", rdy_t, rdy_exp);
    endtask

    task automatic handoff();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
        chk(!rdy && rst_n && !busy, "R8 reset stays high", {rdy, rst_n, busy}, 3'b010);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        srst = 1'b1; go = 1'b0; drv = 1'b0; ack = 1'b0;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        chk(all_off(), "R1 reset state", {rst_n, busy, rdy, strap_oe, scl_oe, sda_oe}, 0);

        // acknowledge in idle has no effect
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
        chk(all_off(), "R8 acknowledge in idle ignored", {rst_n, scl_oe, sda_oe}, 0);

        run_seq(1'b0, "R2");
        handoff();
        run_seq(1'b1, "R10 restart after hand-off");
        run_seq(1'b0, "R10 restart before hand-off");
        handoff();

        // reset mid-sequence
        @(negedge clk); go = 1'b1; drv = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (4) @(negedge clk);
        srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        chk(all_off(), "R11 reset during setup", {rst_n, busy, strap_oe, scl_oe}, 0);

        run_seq(1'b1, "R2");
        @(negedge clk); srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        chk(all_off(), "R11 reset from ready", {rst_n, busy, rdy, scl_oe}, 0);

        finish_run();
    end

endmodule